// File: doc/BRIEF.md
# Configurable output logic macrocell bank

This block models the output stage of a sum-of-products programmable logic device: a row of identical macrocells, each sitting between one OR-summed term coming out of the logic array and one device pin. Every cell holds a single D flip-flop and a small amount of steering logic. Per-cell configuration inputs decide whether the pin follows the registered value or the raw sum term, and whether it is shown in true or inverted form. A per-cell output-enable selector turns the pin driver permanently off, permanently on, or hands it to that cell's own enable product term.

Two terms are shared by every cell in the bank. The clear term empties every flip-flop at once, without waiting for a clock. The set term loads a one into every flip-flop at the next rising edge. Both act on the stored state, not on the pin level, so an inverted cell shows a high pin after a clear. Each cell returns a feedback bit, in true and in complemented form, for the logic array. In registered mode the feedback is the stored state, and the pin is output only. In combinational mode the feedback is taken from the pin side of the driver, so a cell whose driver is off behaves as an input.

A synchronous reset stands in for the power-up clear. A test mode lets a preload value be clocked straight into the flip-flops so that any state can be forced before a sequence is run.

Top module: `outcell_bank`

## Requirements
- R1: In registered mode (`mode_comb[i]`=0, with no clear, set, reset or test mode) the flip-flop of cell i takes `sum_term[i]` at each rising edge, and `pin_out[i]` shows the stored value.
- R2: `pol_true[i]`=1 drives the pin with the selected value unchanged. `pol_true[i]`=0 drives its inverse. This holds in both modes.
- R3: While `clr_term` is 1, every flip-flop reads 0 at once, with no clock edge. It stays 0 after `clr_term` falls, until the next rising edge.
- R4: `pol_true` and `pre_term`: a 1 on `pre_term` sampled at a rising edge leaves every flip-flop at 1 after that edge.
- R5: Clear and set act on the stored state. An inverted registered cell (`pol_true[i]`=0) shows `pin_out[i]`=1 after a clear and 0 after a set.
- R6: In combinational mode (`mode_comb[i]`=1) `pin_out[i]` follows `sum_term[i]`, with the polarity applied, in the same cycle and with no register on the path.
- R7: `fb_true[i]` is the stored value in registered mode, whatever `pin_in[i]` or the enable is. In combinational mode it is `pin_out[i]` when `pin_oe[i]`=1 and `pin_in[i]` when `pin_oe[i]`=0.
- R8: `fb_comp[i]` is always the complement of `fb_true[i]`.
- R9: Output-enable select `oe_mode[2i+1:2i]` uses these codes: 00 keeps `pin_oe[i]`=0, 01 keeps it 1, and 10 or 11 makes it follow `oe_term[i]`.
- R10: `rst`=1 at a rising edge clears every flip-flop to 0.
- R11: When `clr_term` and `pre_term` are both 1 at a rising edge, the flip-flops end at 0.
- R12: With `test_mode`=1 (and no clear, set or reset) a rising edge loads `preload_data[i]` instead of `sum_term[i]`. With `test_mode`=0 `preload_data` has no effect.
- R13: Priority at an edge, from highest to lowest: reset, set, test preload, then the sum term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every cell flip-flop |
| rst | input | 1 | Synchronous active-high power-up clear |
| mode_comb | input | CELLS | Per cell: 1 = combinational, 0 = registered |
| pol_true | input | CELLS | Per cell: 1 = true output, 0 = inverted |
| oe_mode | input | 2*CELLS | Per cell 2-bit enable select: 00 off, 01 on, 1x product term |
| sum_term | input | CELLS | Sum-of-products value for each cell |
| oe_term | input | CELLS | Enable product term for each cell |
| clr_term | input | 1 | Shared asynchronous clear term |
| pre_term | input | 1 | Shared synchronous set term |
| test_mode | input | 1 | Enables the preload path |
| preload_data | input | CELLS | Values to force into the flip-flops in test mode |
| pin_in | input | CELLS | Level driven onto each pin from outside |
| pin_out | output | CELLS | Data each cell drives toward its pin |
| pin_oe | output | CELLS | Pin driver enable for each cell |
| fb_true | output | CELLS | Feedback to the array, true form |
| fb_comp | output | CELLS | Feedback to the array, complemented form |

## Verification
Several storage actions can land on the same rising edge: the clear term against the set term, the set term against a test preload, and reset against the set term. The bench asserts these together on purpose, each in its own cycle, and judges the stored state one cycle later through `pin_out` and `fb_true` of the registered cells. A clear is also raised halfway through a cycle and checked before the next edge, so that its immediate action is told apart from a clocked one. A random phase lets the clear, set, reset and preload inputs coincide freely, and a behavioural model applies the stated priority on every clock.

// File: rtl/outcell_pkg.sv
package outcell_pkg;

  localparam int OE_SEL_W = 2;

  // per-cell output-enable selection codes
  typedef enum logic [OE_SEL_W-1:0] {
    OE_OFF      = 2'b00,
    OE_ON       = 2'b01,
    OE_TERM     = 2'b10,
    OE_TERM_ALT = 2'b11
  } oe_sel_e;

  // decoded per-cell configuration
  typedef struct packed {
    logic    comb;      // 1: pin follows sum term directly
    logic    pol_true;  // 1: no inversion at pin
    oe_sel_e oe_sel;
  } cell_cfg_t;

  function automatic logic oe_resolve(input oe_sel_e sel, input logic term);
    logic en;
    case (sel)
      OE_OFF:  en = 1'b0;
      OE_ON:   en = 1'b1;
      default: en = term;
    endcase
    return en;
  endfunction

endpackage

// File: rtl/outcell_reg.sv
module outcell_reg (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pre,
  input  logic test_mode,
  input  logic preload_d,
  input  logic sum_d,
  output logic q
);

  logic next_d;

  // edge priority: set, then test preload, then the sum term
  always_comb begin
    if (pre)
      next_d = 1'b1;
    else if (test_mode)
      next_d = preload_d;
    else
      next_d = sum_d;
  end

  // clear term acts without a clock; reset stands in for power-up clear
  always_ff @(posedge clk or posedge clr) begin
    if (clr)
      q <= 1'b0;
    else if (rst)
      q <= 1'b0;
    else
      q <= next_d;
  end

endmodule

// File: rtl/outcell_drive.sv
module outcell_drive
  import outcell_pkg::*;
(
  input  cell_cfg_t cfg,
  input  logic      sum_d,
  input  logic      q,
  input  logic      oe_term,
  output logic      pin_d,
  output logic      pin_en
);

  logic core;

  always_comb begin
    core   = cfg.comb ? sum_d : q;
    pin_d  = cfg.pol_true ? core : ~core;
    pin_en = oe_resolve(cfg.oe_sel, oe_term);
  end

endmodule

// File: rtl/outcell_fb.sv
module outcell_fb (
  input  logic comb,
  input  logic q,
  input  logic pin_d,
  input  logic pin_en,
  input  logic pin_in,
  output logic fb_t,
  output logic fb_c
);

  logic pin_side;

  always_comb begin
    // level seen on the pin: own driver when enabled, else outside world
    pin_side = pin_en ? pin_d : pin_in;
    fb_t     = comb ? pin_side : q;
    fb_c     = ~fb_t;
  end

endmodule

// File: rtl/outcell_bank.sv
module outcell_bank
  import outcell_pkg::*;
#(
  parameter int CELLS = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CELLS-1:0]      mode_comb,
  input  logic [CELLS-1:0]      pol_true,
  input  logic [2*CELLS-1:0]    oe_mode,
  input  logic [CELLS-1:0]      sum_term,
  input  logic [CELLS-1:0]      oe_term,
  input  logic                  clr_term,
  input  logic                  pre_term,
  input  logic                  test_mode,
  input  logic [CELLS-1:0]      preload_data,
  input  logic [CELLS-1:0]      pin_in,
  output logic [CELLS-1:0]      pin_out,
  output logic [CELLS-1:0]      pin_oe,
  output logic [CELLS-1:0]      fb_true,
  output logic [CELLS-1:0]      fb_comp
);

  localparam int SEL_W = OE_SEL_W;

  logic [CELLS-1:0] q_vec;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    cell_cfg_t cfg;

    always_comb begin
      cfg.comb     = mode_comb[i];
      cfg.pol_true = pol_true[i];
      cfg.oe_sel   = oe_sel_e'(oe_mode[SEL_W*i +: SEL_W]);
    end

    outcell_reg u_reg (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_term),
      .pre       (pre_term),
      .test_mode (test_mode),
      .preload_d (preload_data[i]),
      .sum_d     (sum_term[i]),
      .q         (q_vec[i])
    );

    outcell_drive u_drive (
      .cfg     (cfg),
      .sum_d   (sum_term[i]),
      .q       (q_vec[i]),
      .oe_term (oe_term[i]),
      .pin_d   (pin_out[i]),
      .pin_en  (pin_oe[i])
    );

    outcell_fb u_fb (
      .comb   (mode_comb[i]),
      .q      (q_vec[i]),
      .pin_d  (pin_out[i]),
      .pin_en (pin_oe[i]),
      .pin_in (pin_in[i]),
      .fb_t   (fb_true[i]),
      .fb_c   (fb_comp[i])
    );
  end

endmodule

// File: rtl/outcell_bank_chk.sv
module outcell_bank_chk #(
  parameter int CELLS = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [CELLS-1:0]   mode_comb,
  input logic [CELLS-1:0]   pol_true,
  input logic [2*CELLS-1:0] oe_mode,
  input logic [CELLS-1:0]   sum_term,
  input logic [CELLS-1:0]   oe_term,
  input logic               clr_term,
  input logic               pre_term,
  input logic               test_mode,
  input logic [CELLS-1:0]   preload_data,
  input logic [CELLS-1:0]   pin_in,
  input logic [CELLS-1:0]   pin_out,
  input logic [CELLS-1:0]   pin_oe,
  input logic [CELLS-1:0]   fb_true,
  input logic [CELLS-1:0]   fb_comp
);

  localparam logic [CELLS-1:0] ALL1 = '1;

  logic [CELLS-1:0] q_seen;     // stored state recovered from the pin
  logic [CELLS-1:0] pin_side;
  logic [CELLS-1:0] off_mask, on_mask, term_mask;

  always_comb begin
    q_seen   = pin_out ~^ pol_true;
    pin_side = (pin_oe & pin_out) | (~pin_oe & pin_in);
    for (int i = 0; i < CELLS; i++) begin
      off_mask[i]  = (oe_mode[2*i +: 2] == 2'b00);
      on_mask[i]   = (oe_mode[2*i +: 2] == 2'b01);
      term_mask[i] = oe_mode[2*i+1];
    end
  end

  // R1: plain edge loads the sum term
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    (!clr_term && !pre_term && !test_mode) |=>
      (clr_term || (((q_seen ^ $past(sum_term)) & ~mode_comb) == '0)));

  // R3: clear shows at once
  a_r3_clear_now: assert property (@(posedge clk) disable iff (rst)
    clr_term |-> ((q_seen & ~mode_comb) == '0));

  // R4: set term loads ones at the edge
  a_r4_preset: assert property (@(posedge clk) disable iff (rst)
    (pre_term && !clr_term) |=> (clr_term || ((q_seen | mode_comb) == ALL1)));

  // R11: clear beats set
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (pre_term && clr_term) |=> ((q_seen & ~mode_comb) == '0));

  // R12: preload path in test mode
  a_r12_preload: assert property (@(posedge clk) disable iff (rst)
    (test_mode && !pre_term && !clr_term) |=>
      (clr_term || (((q_seen ^ $past(preload_data)) & ~mode_comb) == '0)));

  // R7: registered feedback is the stored state
  a_r7_fb_reg: assert property (@(posedge clk) disable iff (rst)
    ((fb_true ^ q_seen) & ~mode_comb) == '0);

  // R7: combinational feedback comes from the pin side
  a_r7_fb_pin: assert property (@(posedge clk) disable iff (rst)
    ((fb_true ^ pin_side) & mode_comb) == '0);

  // R8: complement feedback
  a_r8_fb_comp: assert property (@(posedge clk) disable iff (rst)
    (fb_true ^ fb_comp) == ALL1);

  // R9: enable selection codes
  a_r9_oe_sel: assert property (@(posedge clk) disable iff (rst)
    (((pin_oe & off_mask) == '0) && ((~pin_oe & on_mask) == '0) &&
     (((pin_oe ^ oe_term) & term_mask) == '0)));

  // R6: combinational pin tracks the sum term
  a_r6_comb_pin: assert property (@(posedge clk) disable iff (rst)
    (((pin_out ^ ~(sum_term ^ pol_true)) & mode_comb) == '0));

  // R10: reset leaves every flip-flop cleared
  a_r10_powerup: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((q_seen & ~mode_comb) == '0));

endmodule

bind outcell_bank outcell_bank_chk #(.CELLS(CELLS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_comb    (mode_comb),
  .pol_true     (pol_true),
  .oe_mode      (oe_mode),
  .sum_term     (sum_term),
  .oe_term      (oe_term),
  .clr_term     (clr_term),
  .pre_term     (pre_term),
  .test_mode    (test_mode),
  .preload_data (preload_data),
  .pin_in       (pin_in),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .fb_true      (fb_true),
  .fb_comp      (fb_comp)
);

// File: tb/outcell_bank_bench.sv
`timescale 1ns/1ps
module outcell_bank_bench;

  localparam int N = 4;
  localparam int LIMIT_CYCLES = 20000;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   mode_comb, pol_true, sum_term, oe_term, preload_data, pin_in;
  logic [2*N-1:0] oe_mode;
  logic           clr_term, pre_term, test_mode;
  logic [N-1:0]   pin_out, pin_oe, fb_true, fb_comp;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [N-1:0] ref_q;

  always #2.5 clk = ~clk;

  outcell_bank #(.CELLS(N)) u_outcell_bank (
    .clk(clk), .rst(rst), .mode_comb(mode_comb), .pol_true(pol_true),
    .oe_mode(oe_mode), .sum_term(sum_term), .oe_term(oe_term),
    .clr_term(clr_term), .pre_term(pre_term), .test_mode(test_mode),
    .preload_data(preload_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  task automatic compare(input string tag);
    logic [N-1:0] e_out, e_oe, e_fb;
    for (int i = 0; i < N; i++) begin
      logic v;
      case (oe_mode[2*i +: 2])
        2'b00:   e_oe[i] = 1'b0;
        2'b01:   e_oe[i] = 1'b1;
        default: e_oe[i] = oe_term[i];
      endcase
      v        = mode_comb[i] ? sum_term[i] : ref_q[i];
      e_out[i] = pol_true[i] ? v : !v;
      if (mode_comb[i]) e_fb[i] = e_oe[i] ? e_out[i] : pin_in[i];
      else              e_fb[i] = ref_q[i];
    end
    checks++;
    if (pin_out !== e_out || pin_oe !== e_oe || fb_true !== e_fb || fb_comp !== ~e_fb) begin
      failures++;
      $display("FAIL %s out=%b/%b oe=%b/%b fb=%b/%b fbc=%b/%b (actual/expected)",
               tag, pin_out, e_out, pin_oe, e_oe, fb_true, e_fb, fb_comp, ~e_fb);
    end
  endtask

  // one cycle: inputs were set after a falling edge
  task automatic cyc(input string tag);
    #1;
    if (clr_term) ref_q = '0;
    compare(tag);
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (rst || clr_term)   ref_q[i] = 1'b0;
      else if (pre_term)     ref_q[i] = 1'b1;
      else if (test_mode)    ref_q[i] = preload_data[i];
      else                   ref_q[i] = sum_term[i];
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (LIMIT_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; mode_comb = '0; pol_true = 4'b0101; oe_mode = 8'h55;
    sum_term = '0; oe_term = '0; clr_term = 0; pre_term = 0;
    test_mode = 0; preload_data = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0; ref_q = '0;
    cyc("R10");                               // pins show inverse of polarity

    sum_term = 4'b1100; cyc("R1");
    sum_term = 4'b0011; cyc("R1"); cyc("R1");
    pol_true = 4'b1111; cyc("R2");
    pol_true = 4'b0000; cyc("R2");

    clr_term = 1; cyc("R3");                  // cleared before any edge
    clr_term = 0; sum_term = 4'b1111; cyc("R3");
    cyc("R1");
    clr_term = 1; cyc("R5");                  // inverted pins go high
    clr_term = 0; sum_term = '0; pre_term = 1; cyc("R4");
    pre_term = 0; cyc("R4");                  // ones stored, inverted pins low
    clr_term = 1; pre_term = 1; cyc("R11");
    clr_term = 0; pre_term = 0; cyc("R11");

    pol_true = 4'b1010;
    test_mode = 1; preload_data = 4'b1010; sum_term = 4'b0101; cyc("R12");
    cyc("R12");
    test_mode = 0; preload_data = 4'b1111; sum_term = '0; cyc("R12");
    cyc("R12");                               // preload ignored outside test mode
    test_mode = 1; preload_data = '0; pre_term = 1; cyc("R13");
    test_mode = 0; pre_term = 0; cyc("R13");
    rst = 1; pre_term = 1; cyc("R13");
    rst = 0; pre_term = 0; cyc("R13");

    mode_comb = 4'b1111; pol_true = 4'b0110; sum_term = 4'b1010; cyc("R6");
    sum_term = 4'b0101; cyc("R6");
    oe_mode = {2'b11, 2'b10, 2'b01, 2'b00}; oe_term = 4'b0100; cyc("R9");
    oe_term = 4'b1000; cyc("R9");
    oe_mode = 8'h00; pin_in = 4'b1001; cyc("R7");
    mode_comb = 4'b0000; pin_in = 4'b0110; sum_term = 4'b1100; cyc("R7");
    cyc("R8");

    for (int k = 0; k < 500; k++) begin
      sum_term     = N'($urandom);
      oe_term      = N'($urandom);
      preload_data = N'($urandom);
      pin_in       = N'($urandom);
      clr_term     = ($urandom_range(0, 19) == 0);
      pre_term     = ($urandom_range(0, 9) == 0);
      test_mode    = ($urandom_range(0, 9) == 0);
      rst          = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 15) == 0) begin
        mode_comb = N'($urandom);
        pol_true  = N'($urandom);
        oe_mode   = (2*N)'($urandom);
      end
      cyc("R13 random R1 R7 R8");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule